// File: doc/BRIEF.md
# Smart Card Character Transmitter with Error-Driven Resend

This block sends one byte at a time over a single open-drain line as an asynchronous smart-card character. A character is a low start bit, eight data bits and one parity bit. Every bit lasts one elementary time unit (etu), which is a whole number of clock cycles given by a divisor input. The block only pulls the line low or releases it. A pull-up or the card makes the released level high.

After the parity bit the block keeps listening to the line. A receiver that finds a parity problem pulls the line low for about one etu. If the transmitter sees that pulse at its sample point, it waits a guard interval and then sends the same byte again without help from the host. A programmable limit caps the number of resends. Once the limit is used up, a failure pulse ends the attempt. The host hands over bytes through a valid/ready pair. The bit order, level inversion, parity sense, etu divisor and retry limit are captured when a byte is accepted and stay fixed for that byte's whole exchange.

Top module: `sc_char_tx`

## Requirements
- R1: After a byte is accepted, the line carries 10 bits: a low start bit, 8 data bits and a parity bit. Each bit lasts N clock cycles, where N = `etu_div` (a value of 0 acts as 1). Slot k occupies cycles k*N to k*N+N-1, counted from the cycle after the accepting edge.
- R2: With `cfg_msb_first`=0 and `cfg_invert`=0 (direct convention), data goes out LSB first (slot 1 carries bit 0, slot 8 carries bit 7). A 1 is sent as the released (high) level and a 0 as the low level.
- R3: The parity slot is chosen so that the number of high levels across slots 1..9 is even when `cfg_odd_parity`=0 and odd when it is 1.
- R4: `cfg_msb_first`=1 sends bit 7 first (slot 1) and bit 0 last (slot 8). `cfg_invert`=1 complements every data level. Parity (R3) is counted over the levels actually sent, and the start bit stays low in every configuration.
- R5: `line_oe` is high only in a slot whose level is low. It stays low from the end of the parity slot until the next start bit, so the line is released during listening and guard time.
- R6: `tx_ready` is high exactly while idle. A byte is accepted on a rising edge with `tx_valid` and `tx_ready` both high, and `tx_ready` is low for the whole exchange that follows.
- R7: The line is sampled on the edge that ends slot 10 (11*N cycles after acceptance). If it is high, `tx_done` pulses for one cycle at cycle 12*N and `tx_ready` returns in that same cycle. This leaves at least 2 etu of released line after the parity bit.
- R8: If the line is low at the R7 sample point and `retry_cnt` is below the captured `retry_max`, `retry_cnt` increments and the same byte's start bit begins 14*N cycles after the previous start. This is at least 2 etu after the error pulse ends.
- R9: If the line is low at the sample point and `retry_cnt` equals the captured `retry_max`, no resend happens. `tx_fail` pulses for one cycle at cycle 14*N of that attempt and the block returns to idle. `tx_done` and `tx_fail` are never high together.
- R10: While reset is asserted and after it is released, `tx_ready`=1, `line_oe`=0, `tx_done`=0, `tx_fail`=0 and `retry_cnt`=0. `retry_cnt` clears when a new byte is accepted and otherwise holds its last value while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Block idle, byte can be accepted |
| cfg_msb_first | input | 1 | Send the most significant bit first |
| cfg_invert | input | 1 | Complement the data levels |
| cfg_odd_parity | input | 1 | Odd parity instead of even |
| etu_div | input | 12 | Clock cycles per etu |
| retry_max | input | 3 | Maximum number of resends for one byte |
| line_in | input | 1 | Sampled level of the shared I/O line |
| line_oe | output | 1 | Pull the line low when high, release it when low |
| tx_done | output | 1 | One-cycle pulse: byte delivered without error |
| tx_fail | output | 1 | One-cycle pulse: retry limit used up |
| retry_cnt | output | 3 | Resends made for the current or last byte |

## Verification
On every cycle, the assertions check the etu tick spacing and that the line is released after the parity slot. They also check that the done and fail pulses are single-cycle and never overlap, that the resend count steps by one and stays within the captured limit, and that an accepted byte always starts an exchange. Whether the sent levels match the byte, its bit order, inversion and parity can only be shown by the bench: it sweeps every byte value under all eight configuration combinations and decodes the line at mid-etu. The same holds for the exact cycles of the sample point, the resend start and the done and fail pulses, which the bench checks by injecting receiver error pulses against several retry limits and divisors.

// File: rtl/sc_tx_pkg.sv
package sc_tx_pkg;
  localparam int DATA_W      = 8;
  localparam int FRAME_W     = DATA_W + 2;   // start + data + parity
  localparam int SLOT_W      = 4;
  localparam int SLOT_SAMPLE = FRAME_W;      // etu after parity, sampled at its end
  localparam int SLOT_DONE   = FRAME_W + 1;  // last guard etu on success
  localparam int SLOT_RESEND = FRAME_W + 3;  // last back-off etu after an error

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } tx_state_e;
endpackage

// File: rtl/sc_etu_timer.sv
module sc_etu_timer #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + {{DIV_W{1'b0}}, 1'b1};
  assign tick    = !clr && (cnt_inc >= {1'b0, div});

  always_comb begin
    if (clr || tick) cnt_d = '0;
    else             cnt_d = cnt_inc[DIV_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // one etu is never shorter than the divisor asks for
  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div > 1) |=> !tick);  // R1
endmodule

// File: rtl/sc_char_encoder.sv
module sc_char_encoder
  import sc_tx_pkg::*;
(
  input  logic [DATA_W-1:0]  data,
  input  logic               msb_first,
  input  logic               invert,
  input  logic               odd_parity,
  output logic [FRAME_W-1:0] levels
);
  logic [DATA_W-1:0] lvl;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign lvl[i] = (msb_first ? data[DATA_W-1-i] : data[i]) ^ invert;
  end

  assign levels = {(^lvl) ^ odd_parity, lvl, 1'b0};
endmodule

// File: rtl/sc_tx_ctrl.sv
module sc_tx_ctrl
  import sc_tx_pkg::*;
#(
  parameter int DIV_W = 12,
  parameter int RTY_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_valid,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [DIV_W-1:0]   div_in,
  input  logic [RTY_W-1:0]   rmax_in,
  input  logic               line_in,
  input  logic               tick,
  output logic               tx_ready,
  output logic               line_oe,
  output logic               tx_done,
  output logic               tx_fail,
  output logic [RTY_W-1:0]   retry_cnt,
  output logic               timer_clr,
  output logic [DIV_W-1:0]   div_q
);
  tx_state_e          state_q, state_d;
  logic [SLOT_W-1:0]  slot_q, slot_d;
  logic [FRAME_W-1:0] frame_q, frame_d, frame_sh;
  logic [DIV_W-1:0]   div_d;
  logic [RTY_W-1:0]   rmax_q, rmax_d, rcnt_q, rcnt_d;
  logic               err_q, err_d, done_q, done_d, fail_q, fail_d;
  logic               busy, accept;

  assign busy   = (state_q == ST_BUSY);
  assign accept = !busy && tx_valid;

  always_comb begin
    state_d = state_q;
    slot_d  = slot_q;
    frame_d = frame_q;
    div_d   = div_q;
    rmax_d  = rmax_q;
    rcnt_d  = rcnt_q;
    err_d   = err_q;
    done_d  = 1'b0;
    fail_d  = 1'b0;
    if (!busy) begin
      if (accept) begin
        state_d = ST_BUSY;
        slot_d  = '0;
        frame_d = frame_in;
        div_d   = div_in;
        rmax_d  = rmax_in;
        rcnt_d  = '0;
        err_d   = 1'b0;
      end
    end else if (tick) begin
      if (slot_q == SLOT_W'(SLOT_SAMPLE)) begin
        err_d  = !line_in;
        slot_d = slot_q + SLOT_W'(1);
      end else if (slot_q == SLOT_W'(SLOT_DONE) && !err_q) begin
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end else if (slot_q == SLOT_W'(SLOT_RESEND)) begin
        if (rcnt_q == rmax_q) begin
          fail_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          rcnt_d = rcnt_q + RTY_W'(1);
          slot_d = '0;
          err_d  = 1'b0;
        end
      end else begin
        slot_d = slot_q + SLOT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      frame_q <= '1;
      div_q   <= '0;
      rmax_q  <= '0;
      rcnt_q  <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
      frame_q <= frame_d;
      div_q   <= div_d;
      rmax_q  <= rmax_d;
      rcnt_q  <= rcnt_d;
      err_q   <= err_d;
      done_q  <= done_d;
      fail_q  <= fail_d;
    end
  end

  assign frame_sh  = frame_q >> slot_q;
  assign line_oe   = busy && (slot_q < SLOT_W'(FRAME_W)) && !frame_sh[0];
  assign tx_ready  = !busy;
  assign tx_done   = done_q;
  assign tx_fail   = fail_q;
  assign retry_cnt = rcnt_q;
  assign timer_clr = !busy;

  AST_LINE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_q >= SLOT_W'(FRAME_W)) |-> !line_oe);  // R5
  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);  // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);  // R7
  AST_FAIL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fail |=> !tx_fail);  // R9
  AST_DONE_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_done && tx_fail));  // R9
  AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (retry_cnt <= rmax_q));  // R9
  AST_RETRY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (retry_cnt == $past(retry_cnt) ||
              retry_cnt == $past(retry_cnt) + RTY_W'(1)));  // R8
endmodule

// File: rtl/sc_char_tx.sv
module sc_char_tx
  import sc_tx_pkg::*;
#(
  parameter int DIV_W = 12,
  parameter int RTY_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic              cfg_msb_first,
  input  logic              cfg_invert,
  input  logic              cfg_odd_parity,
  input  logic [DIV_W-1:0]  etu_div,
  input  logic [RTY_W-1:0]  retry_max,
  input  logic              line_in,
  output logic              line_oe,
  output logic              tx_done,
  output logic              tx_fail,
  output logic [RTY_W-1:0]  retry_cnt
);
  logic [FRAME_W-1:0] frame_lv;
  logic [DIV_W-1:0]   div_lat;
  logic               tick, timer_clr;

  sc_char_encoder u_enc (
    .data       (tx_data),
    .msb_first  (cfg_msb_first),
    .invert     (cfg_invert),
    .odd_parity (cfg_odd_parity),
    .levels     (frame_lv)
  );

  sc_etu_timer #(.DIV_W(DIV_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (timer_clr),
    .div   (div_lat),
    .tick  (tick)
  );

  sc_tx_ctrl #(.DIV_W(DIV_W), .RTY_W(RTY_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_valid  (tx_valid),
    .frame_in  (frame_lv),
    .div_in    (etu_div),
    .rmax_in   (retry_max),
    .line_in   (line_in),
    .tick      (tick),
    .tx_ready  (tx_ready),
    .line_oe   (line_oe),
    .tx_done   (tx_done),
    .tx_fail   (tx_fail),
    .retry_cnt (retry_cnt),
    .timer_clr (timer_clr),
    .div_q     (div_lat)
  );
endmodule

// File: tb/tb_sc_char_tx.sv
`timescale 1ns/1ps
module tb_sc_char_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  tx_data = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic        cfg_msb_first = 1'b0, cfg_invert = 1'b0, cfg_odd_parity = 1'b0;
  logic [11:0] etu_div = 12'd2;
  logic [2:0]  retry_max = 3'd0;
  logic        line_oe, tx_done, tx_fail;
  logic [2:0]  retry_cnt;
  logic        card_pull = 1'b0;
  logic        line;
  int          n_checks = 0, n_fails = 0;

  always #2 clk = ~clk;

  assign line = !(line_oe || card_pull);

  sc_char_tx dut (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .cfg_msb_first(cfg_msb_first), .cfg_invert(cfg_invert),
    .cfg_odd_parity(cfg_odd_parity), .etu_div(etu_div), .retry_max(retry_max),
    .line_in(line), .line_oe(line_oe), .tx_done(tx_done), .tx_fail(tx_fail),
    .retry_cnt(retry_cnt)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // expected line levels for slots 0..9, built from the requirement text
  function automatic logic [9:0] expect_levels(input logic [7:0] d, input bit msb,
                                               input bit inv, input bit odd);
    logic [9:0] r;
    int ones;
    r = '0;
    ones = 0;
    for (int k = 1; k <= 8; k++) begin
      r[k] = (msb ? d[8-k] : d[k-1]) ^ inv;
      if (r[k]) ones++;
    end
    r[9] = ((ones % 2) == 1) ? !odd : odd;
    return r;
  endfunction

  task automatic run_char(input logic [7:0] d, input bit msb, input bit inv, input bit odd,
                          input int n, input int rmax, input int nerr, input string tag);
    logic [9:0] ex;
    logic [9:0] got;
    int c, a, r, per;
    bit fin;
    ex = expect_levels(d, msb, inv, odd);
    per = 14 * n;
    tx_data = d; cfg_msb_first = msb; cfg_invert = inv; cfg_odd_parity = odd;
    etu_div = 12'(n); retry_max = 3'(rmax); tx_valid = 1'b1;
    check(tx_ready === 1'b1, "R6 ready before accept", tx_ready, 1);
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    c = 0; fin = 0; got = '0;
    while (!fin) begin
      a = c / per; r = c % per;
      for (int k = 0; k < 10; k++)
        if (r == k * n + n / 2) got[k] = line;
      if (r == 9 * n + n / 2)
        check(got == ex, {tag, " R1 R2 R3 R4 frame levels"}, got, ex);
      if (a == 0 && r == n)
        check(tx_ready === 1'b0, "R6 ready low while busy", tx_ready, 0);
      card_pull = (a < nerr) && (r >= 10 * n + n / 2) && (r < 11 * n + n / 2);
      if (a >= nerr) begin
        if (r == 11 * n + n / 2)
          check(line === 1'b1 && line_oe === 1'b0, "R5 guard released", line_oe, 0);
        if (r == 12 * n - 1)
          check(tx_done === 1'b0 && tx_ready === 1'b0, "R7 no early done", tx_done, 0);
        if (r == 12 * n) begin
          check(tx_done === 1'b1 && tx_ready === 1'b1 && tx_fail === 1'b0,
                "R7 done timing", {tx_done, tx_ready, tx_fail}, 3'b110);
          check(retry_cnt == 3'(nerr), "R8 retry count", retry_cnt, nerr);
          fin = 1;
        end
      end else if (a == rmax) begin
        if (r == per) ;
        if (r == per - 1)
          check(tx_fail === 1'b0 && line === 1'b1, "R9 no early fail", tx_fail, 0);
      end else begin
        if (r == per - 1)
          check(line === 1'b1 && tx_ready === 1'b0, "R8 back-off released", line, 1);
      end
      if (nerr > rmax && c == (rmax + 1) * per) begin
        check(tx_fail === 1'b1 && tx_done === 1'b0 && tx_ready === 1'b1,
              "R9 fail pulse", {tx_fail, tx_done, tx_ready}, 3'b101);
        check(retry_cnt == 3'(rmax), "R9 retry count at limit", retry_cnt, rmax);
        fin = 1;
      end
      if (!fin) begin
        @(negedge clk);
        c++;
      end
    end
    card_pull = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state while held
    check(tx_ready === 1'b1 && line_oe === 1'b0 && tx_done === 1'b0 &&
          tx_fail === 1'b0 && retry_cnt == 3'd0, "R10 reset state", line_oe, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(tx_ready === 1'b1 && line_oe === 1'b0 && retry_cnt == 3'd0,
          "R10 state after release", tx_ready, 1);
    // exhaustive sweep of bytes and configurations, 2-cycle etu
    for (int cfg = 0; cfg < 8; cfg++)
      for (int b = 0; b < 256; b++)
        run_char(8'(b), cfg[0], cfg[1], cfg[2], 2, 0, 0, "sweep");
    // other divisors
    run_char(8'h3B, 1'b0, 1'b0, 1'b0, 3, 0, 0, "div3");
    run_char(8'hA5, 1'b1, 1'b1, 1'b0, 5, 0, 0, "div5");
    // error pulses and resends
    run_char(8'h5C, 1'b0, 1'b0, 1'b0, 3, 2, 1, "one retry");
    run_char(8'hC3, 1'b1, 1'b1, 1'b1, 4, 3, 2, "two retries");
    run_char(8'h81, 1'b0, 1'b0, 1'b1, 3, 2, 3, "limit reached");
    // R10 count holds while idle, then clears on next accept
    repeat (3) @(negedge clk);
    check(retry_cnt == 3'd2, "R10 retry count holds in idle", retry_cnt, 2);
    run_char(8'h00, 1'b0, 1'b0, 1'b0, 4, 0, 1, "no retries allowed");
    run_char(8'hFF, 1'b0, 1'b0, 1'b0, 2, 1, 0, "clean after fail");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule